// File: doc/BRIEF.md
# Periodic Interval Pulse Generator

This block derives periodic pulses from the nominal tick strobe of a nanosecond time counter. Each generator holds a down-counter that loses one tick period, in nanoseconds, on every nominal tick. When the next step would take the count below zero, the counter reloads from its period value and a pulse starts. The period value is written as the wanted interval in nanoseconds less one tick period. For example, with a 10 ns tick, 999999990 gives one pulse per second and 99990 gives a 10 kHz train when the prescaler is 100.

Several generators share the tick strobe, the tick period and the prescaler ratio. Each generator has its own enable, its own period value and its own pulse output. A pulse lasts one prescaled output-clock period. This is expressed as the prescaler ratio counted in nominal ticks, so every generator sees the same width.

Top module: `ppg_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every pulse output is 0.
- R2: An enabled generator with period value P and tick period T reloads once every floor(P/T)+1 nominal ticks. A value of N*T-T therefore gives an interval of exactly N ticks. The pulse rises only in the cycle after a clock edge at which the tick strobe was high.
- R3: After a generator is enabled, its first pulse starts at the tick that completes the first full interval. No pulse is emitted before that tick.
- R4: A pulse stays high for W nominal ticks, where W is the prescaler ratio. A ratio of 0 counts as 1.
- R5: A new period value written during an interval does not shorten or lengthen that interval. The new value takes effect at the next reload.
- R6: If the interval is W ticks or shorter, each reload restarts the width count before it expires, so the output stays high continuously.
- R7: A disabled generator drives its pulse low from the next cycle on. While disabled, its counter follows the period value.
- R8: Each generator runs on its own enable and period value, and is not disturbed by the settings of the others.
- R9: In a cycle without a tick strobe, an enabled generator's pulse output keeps its value into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Nominal tick strobe, one cycle per tick |
| tick_period_i | input | TP_W | Tick period in nanoseconds |
| prescale_i | input | PS_W | Prescaler ratio; pulse width in ticks |
| enable_i | input | NUM_GEN | Per-generator enable |
| period_i | input | NUM_GEN*PER_W | Per-generator period values, generator 0 in the low bits |
| pulse_o | output | NUM_GEN | Per-generator registered pulse output |

## Verification
Two things can fall on the same tick: a reload that starts a new pulse, and the last decrement of the width count of the previous pulse. The bench provokes this by giving one generator an interval of two ticks against a width of three, and later against a width of one. It also runs a generator whose interval equals the width. A reference model counts ticks since enable and decides whether the output should hold high or drop for one cycle. Every cycle is compared against that model. This covers the continuous-high case, and the case where a short gap must appear between pulses.

// File: rtl/ppg_pkg.sv
package ppg_pkg;

    localparam int PPG_NUM_GEN = 3;
    localparam int PPG_PER_W   = 32;
    localparam int PPG_TP_W    = 8;
    localparam int PPG_PS_W    = 8;

    // what the interval counter does in a given cycle
    typedef enum logic [1:0] {
        ACT_LOAD = 2'd0,   // disabled: follow the period value
        ACT_HOLD = 2'd1,   // enabled, no tick
        ACT_STEP = 2'd2,   // enabled, tick, count stays non-negative
        ACT_WRAP = 2'd3    // enabled, tick, count would go negative
    } ppg_act_e;

    // per-channel status carried from the counter to the stretcher
    typedef struct packed {
        logic run;     // generator enabled
        logic fire;    // reload happened at this edge
        logic tick;    // tick strobe at this edge
    } ppg_evt_t;

endpackage

// File: rtl/ppg_interval.sv
module ppg_interval
    import ppg_pkg::*;
#(
    parameter int PER_W = PPG_PER_W,
    parameter int TP_W  = PPG_TP_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             tick_i,
    input  logic [TP_W-1:0]  tick_period_i,
    input  logic [PER_W-1:0] period_i,
    output ppg_evt_t         evt_o
);
    localparam int PAD_W = PER_W - TP_W;

    logic [PER_W-1:0] cnt_q;
    logic [PER_W-1:0] step_w;
    ppg_act_e         act;

    assign step_w = {{PAD_W{1'b0}}, tick_period_i};

    always_comb begin
        if (!en_i)              act = ACT_LOAD;
        else if (!tick_i)       act = ACT_HOLD;
        else if (cnt_q < step_w) act = ACT_WRAP;
        else                    act = ACT_STEP;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            unique case (act)
                ACT_LOAD: cnt_q <= period_i;
                ACT_HOLD: cnt_q <= cnt_q;
                ACT_STEP: cnt_q <= cnt_q - step_w;
                ACT_WRAP: cnt_q <= period_i;
            endcase
        end
    end

    assign evt_o.run  = en_i;
    assign evt_o.fire = (act == ACT_WRAP);
    assign evt_o.tick = tick_i;

endmodule

// File: rtl/ppg_width.sv
module ppg_width
    import ppg_pkg::*;
#(
    parameter int PS_W = PPG_PS_W
) (
    input  logic            clk,
    input  logic            rst,
    input  ppg_evt_t        evt_i,
    input  logic [PS_W-1:0] prescale_i,
    output logic            pulse_o
);
    logic [PS_W-1:0] wcnt_q, wcnt_d;
    logic [PS_W-1:0] width_w;
    logic            pulse_q;

    assign width_w = (prescale_i == '0) ? PS_W'(1) : prescale_i;

    always_comb begin
        wcnt_d = wcnt_q;
        if (!evt_i.run)
            wcnt_d = '0;
        else if (evt_i.fire)
            wcnt_d = width_w;
        else if (evt_i.tick && wcnt_q != '0)
            wcnt_d = wcnt_q - PS_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wcnt_q  <= '0;
            pulse_q <= 1'b0;
        end else begin
            wcnt_q  <= wcnt_d;
            pulse_q <= (wcnt_d != '0);
        end
    end

    assign pulse_o = pulse_q;

endmodule

// File: rtl/ppg_channel.sv
module ppg_channel
    import ppg_pkg::*;
#(
    parameter int PER_W = PPG_PER_W,
    parameter int TP_W  = PPG_TP_W,
    parameter int PS_W  = PPG_PS_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             tick_i,
    input  logic [TP_W-1:0]  tick_period_i,
    input  logic [PS_W-1:0]  prescale_i,
    input  logic [PER_W-1:0] period_i,
    output logic             pulse_o
);
    ppg_evt_t evt;

    ppg_interval #(.PER_W(PER_W), .TP_W(TP_W)) u_intv (
        .clk           (clk),
        .rst           (rst),
        .en_i          (en_i),
        .tick_i        (tick_i),
        .tick_period_i (tick_period_i),
        .period_i      (period_i),
        .evt_o         (evt)
    );

    ppg_width #(.PS_W(PS_W)) u_wid (
        .clk        (clk),
        .rst        (rst),
        .evt_i      (evt),
        .prescale_i (prescale_i),
        .pulse_o    (pulse_o)
    );

endmodule

// File: rtl/ppg_top.sv
module ppg_top
    import ppg_pkg::*;
#(
    parameter int NUM_GEN = PPG_NUM_GEN,
    parameter int PER_W   = PPG_PER_W,
    parameter int TP_W    = PPG_TP_W,
    parameter int PS_W    = PPG_PS_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     tick_i,
    input  logic [TP_W-1:0]          tick_period_i,
    input  logic [PS_W-1:0]          prescale_i,
    input  logic [NUM_GEN-1:0]       enable_i,
    input  logic [NUM_GEN*PER_W-1:0] period_i,
    output logic [NUM_GEN-1:0]       pulse_o
);
    for (genvar g = 0; g < NUM_GEN; g++) begin : g_ch
        ppg_channel #(.PER_W(PER_W), .TP_W(TP_W), .PS_W(PS_W)) u_ch (
            .clk           (clk),
            .rst           (rst),
            .en_i          (enable_i[g]),
            .tick_i        (tick_i),
            .tick_period_i (tick_period_i),
            .prescale_i    (prescale_i),
            .period_i      (period_i[g*PER_W +: PER_W]),
            .pulse_o       (pulse_o[g])
        );
    end

endmodule

// File: rtl/ppg_top_chk.sv
module ppg_top_chk #(
    parameter int NUM_GEN = 3
) (
    input logic               clk,
    input logic               rst,
    input logic               tick_i,
    input logic [NUM_GEN-1:0] enable_i,
    input logic [NUM_GEN-1:0] pulse_o
);
    AST_RST_CLEARS: assert property (@(posedge clk) rst |=> (pulse_o == '0)); // R1

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_chk
        AST_RISE_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
            $rose(pulse_o[g]) |-> $past(tick_i)); // R2
        AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (rst)
            !enable_i[g] |=> !pulse_o[g]); // R7
        AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
            (enable_i[g] && !tick_i) |=> $stable(pulse_o[g])); // R9
    end

endmodule

bind ppg_top ppg_top_chk #(.NUM_GEN(NUM_GEN)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick_i   (tick_i),
    .enable_i (enable_i),
    .pulse_o  (pulse_o)
);

// File: tb/sim_ppg_top.sv
module sim_ppg_top;
    localparam int CLK_PERIOD = 10;
    localparam int NG = 3;
    localparam int PW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick = 1'b0;
    logic [7:0]    tp = 8'd10;
    logic [7:0]    ps = 8'd3;
    logic [NG-1:0] en = '0;
    logic [PW-1:0] per [NG];
    logic [NG*PW-1:0] per_flat;
    logic [NG-1:0] pulse;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    logic [NG-1:0] exp_q [$];
    string         tag_q [$];

    int rem [NG];
    int hl  [NG];

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb
        for (int i = 0; i < NG; i++) per_flat[i*PW +: PW] = per[i];

    ppg_top u0 (
        .clk           (clk),
        .rst           (rst),
        .tick_i        (tick),
        .tick_period_i (tp),
        .prescale_i    (ps),
        .enable_i      (en),
        .period_i      (per_flat),
        .pulse_o       (pulse)
    );

    function automatic int interval_of(input logic [PW-1:0] p);
        return int'(p / PW'(tp)) + 1;
    endfunction

    // driver: apply inputs, predict the outputs after the coming edge, queue them
    task automatic step(input bit tk);
        logic [NG-1:0] e;
        int w;
        tick = tk;
        w = (ps == 0) ? 1 : int'(ps);
        for (int i = 0; i < NG; i++) begin
            if (!en[i]) begin
                rem[i] = interval_of(per[i]);
                hl[i]  = 0;
            end else if (tk) begin
                rem[i]--;
                if (rem[i] == 0) begin
                    hl[i]  = w;
                    rem[i] = interval_of(per[i]);
                end else if (hl[i] > 0) begin
                    hl[i]--;
                end
            end
            e[i] = (hl[i] > 0);
        end
        @(posedge clk);
        exp_q.push_back(e);
        tag_q.push_back(cur_req);
        #1;
    endtask

    task automatic run(input int n, input int tick_every);
        for (int k = 0; k < n; k++) step((k % tick_every) == 0);
    endtask

    // monitor: compare each produced output against the queued prediction
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [NG-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (pulse !== e) begin
                errors++;
                $display("FAIL %s pulse actual=%b expected=%b at %0t", t, pulse, e, $time);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        per[0] = 32'd40;   // 5 ticks
        per[1] = 32'd25;   // 3 ticks (not a multiple of the tick period)
        per[2] = 32'd10;   // 2 ticks, shorter than width 3
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        // R1: outputs low while in reset
        checks++;
        if (pulse !== '0) begin
            errors++;
            $display("FAIL R1 pulse actual=%b expected=000", pulse);
        end
        rst = 1'b0;
        cur_req = "R1";
        run(3, 1);

        // R2 R3 R4 R6 R8: enable all, ticks every other cycle
        cur_req = "R2 R3 R4 R6 R8";
        en = 3'b111;
        run(60, 2);

        // R5: change generator 0 period mid-interval (5 ticks -> 8 ticks)
        cur_req = "R5";
        run(4, 1);
        per[0] = 32'd70;
        run(40, 1);

        // R7: disable generator 1 for a while, others keep running (R8)
        cur_req = "R7 R8";
        en[1] = 1'b0;
        run(12, 1);
        en[1] = 1'b1;
        run(20, 1);

        // R4 R6: width 0 counts as 1; generator 2 now drops between pulses
        cur_req = "R4 R6";
        ps = 8'd0;
        run(24, 1);
        ps = 8'd2;
        per[1] = 32'd10;  // interval 2 equals width 2: continuous high
        run(24, 1);

        // R9: no ticks, outputs frozen
        cur_req = "R9";
        run(10, 1000);

        // R3: re-enable from scratch, first pulse only after a full interval
        cur_req = "R3";
        en = '0;
        ps = 8'd1;
        per[0] = 32'd30;
        run(3, 1);
        en = 3'b111;
        run(20, 1);

        @(negedge clk);
        @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule